// File: doc/BRIEF.md
# Sweep Blanking Interval Controller

This block produces a blanking gate for a frequency sweep. A single-cycle request pulse opens the gate. The gate then stays open for a fixed amount of swept frequency, not for a fixed time. Each sweep tick means the output frequency has moved up by 1 Hz, so the block measures the interval by counting ticks while the gate is open. While the gate is asserted, the downstream RF stage mutes its sweep output.

Two interval widths can be chosen: a narrow 20 kHz span and a wide 60 kHz span. The width is sampled when the interval starts. A new request during an open interval starts the count again from the beginning. Stopping the sweep, or applying reset, closes the gate at once. Choosing which frequencies get blanked is the job of the logic that issues the requests.

Top module: `sweep_blank_ctrl`

## Requirements
- R1: A request sampled high on a clock edge while `sweep_run_i` is high makes `blank_gate_o` read 1 in the cycle after that edge. The gate never rises unless such a request came first.
- R2: The interval length depends on `wide_sel_i` at the request edge. A value of 0 selects 20000 ticks (20 kHz). A value of 1 selects 60000 ticks (60 kHz).
- R3: If a tick is high on every cycle from the request onward, the gate reads 1 for exactly the selected number of cycles. It falls in the cycle after the edge that samples the final counted tick.
- R4: Cycles without a tick do not shorten the interval. The gate holds while `sweep_tick_i` is low.
- R5: A request that arrives while the gate is open reloads the full count, using the width selected at that moment. The gate stays high throughout.
- R6: When `sweep_run_i` is low, `blank_gate_o` reads 0 in that same cycle and the open interval is discarded. A request while the sweep is stopped is ignored. Raising `sweep_run_i` again does not reopen the gate.
- R7: Synchronous active-high reset `rst_i` forces the gate to 0 and discards any interval in progress.
- R8: Changing `wide_sel_i` while an interval is open does not change that interval's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| blank_req_i | input | 1 | Blanking request pulse |
| sweep_tick_i | input | 1 | One-cycle enable per 1 Hz sweep advance |
| wide_sel_i | input | 1 | Interval width: 0 = 20 kHz, 1 = 60 kHz |
| sweep_run_i | input | 1 | High while the sweep is running |
| blank_gate_o | output | 1 | Blanking gate, high mutes the RF output |

## Verification
The assertions check on every cycle that:
- the gate opens one cycle after each accepted request;
- the gate never opens without a request;
- the gate is shut in the cycle after a stopped-sweep cycle;
- the gate does not close on a cycle that had no tick while the sweep kept running.

The exact lengths of 20000 and 60000 ticks can only be shown by the bench's scenarios. The same holds for the length after a restart, for ignoring a width change mid-interval, and for a reset that discards an open interval. Each scenario counts the cycles the gate stays high.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic {
        SPAN_NARROW = 1'b0,
        SPAN_WIDE   = 1'b1
    } span_e;

    typedef enum logic {
        GATE_IDLE  = 1'b0,
        GATE_BLANK = 1'b1
    } gate_state_e;

    localparam int unsigned DEF_NARROW_TICKS = 20000;
    localparam int unsigned DEF_WIDE_TICKS   = 60000;

    function automatic int unsigned span_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned span_ticks(input span_e sel,
                                               input int unsigned narrow_ticks,
                                               input int unsigned wide_ticks);
        return (sel == SPAN_WIDE) ? wide_ticks : narrow_ticks;
    endfunction

endpackage

// File: rtl/sbc_span_sel.sv
module sbc_span_sel
    import sbc_pkg::*;
#(
    parameter int unsigned NARROW_TICKS = DEF_NARROW_TICKS,
    parameter int unsigned WIDE_TICKS   = DEF_WIDE_TICKS,
    parameter int unsigned CNT_W        = 16
) (
    input  logic             wide_sel_i,
    output logic [CNT_W-1:0] span_o
);
    span_e       sel;
    int unsigned ticks;

    always_comb begin
        sel    = span_e'(wide_sel_i);
        ticks  = span_ticks(sel, NARROW_TICKS, WIDE_TICKS);
        span_o = ticks[CNT_W-1:0];
    end
endmodule

// File: rtl/sbc_tick_counter.sv
module sbc_tick_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= load_val_i;
        end else if (dec_i && (remain_q != '0)) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign last_o = (remain_q == ONE);
endmodule

// File: rtl/sbc_gate_fsm.sv
module sbc_gate_fsm
    import sbc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic start_i,
    input  logic tick_i,
    input  logic last_i,
    output logic active_o
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = GATE_IDLE;
        end else if (start_i) begin
            state_d = GATE_BLANK;
        end else if ((state_q == GATE_BLANK) && tick_i && last_i) begin
            state_d = GATE_IDLE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= GATE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign active_o = (state_q == GATE_BLANK);
endmodule

// File: rtl/sweep_blank_ctrl.sv
module sweep_blank_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned NARROW_TICKS = DEF_NARROW_TICKS,
    parameter int unsigned WIDE_TICKS   = DEF_WIDE_TICKS
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic blank_req_i,
    input  logic sweep_tick_i,
    input  logic wide_sel_i,
    input  logic sweep_run_i,
    output logic blank_gate_o
);
    localparam int unsigned MAX_TICKS = span_max(NARROW_TICKS, WIDE_TICKS);
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic             start;
    logic             active;
    logic             last;
    logic             dec;
    logic [CNT_W-1:0] span;

    assign start = blank_req_i && sweep_run_i;
    assign dec   = active && sweep_tick_i && !start;

    sbc_span_sel #(
        .NARROW_TICKS (NARROW_TICKS),
        .WIDE_TICKS   (WIDE_TICKS),
        .CNT_W        (CNT_W)
    ) span_i (
        .wide_sel_i (wide_sel_i),
        .span_o     (span)
    );

    sbc_tick_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (start),
        .load_val_i (span),
        .dec_i      (dec),
        .last_o     (last)
    );

    sbc_gate_fsm fsm_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (sweep_run_i),
        .start_i  (start),
        .tick_i   (sweep_tick_i),
        .last_i   (last),
        .active_o (active)
    );

    assign blank_gate_o = active && sweep_run_i;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker (
    input logic clk_i,
    input logic rst_i,
    input logic blank_req_i,
    input logic sweep_tick_i,
    input logic sweep_run_i,
    input logic blank_gate_o
);
    AST_OPEN_AFTER_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        (blank_req_i && sweep_run_i) |=> (blank_gate_o || !sweep_run_i)); // R1

    AST_NO_UNREQUESTED_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(blank_gate_o) |-> $past(blank_req_i && sweep_run_i)); // R1

    AST_STOP_SHUTS_GATE: assert property (@(posedge clk_i) disable iff (rst_i)
        !sweep_run_i |=> !blank_gate_o); // R6

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        (blank_gate_o && !sweep_tick_i && sweep_run_i) |=> (blank_gate_o || !sweep_run_i)); // R4

    AST_CLOSE_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(blank_gate_o) && sweep_run_i) |-> $past(sweep_tick_i)); // R3
endmodule

bind sweep_blank_ctrl sbc_checker chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .blank_req_i  (blank_req_i),
    .sweep_tick_i (sweep_tick_i),
    .sweep_run_i  (sweep_run_i),
    .blank_gate_o (blank_gate_o)
);

// File: tb/sweep_blank_ctrl_tb.sv
module sweep_blank_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NARROW = 20000;
    localparam int WIDE   = 60000;
    localparam int WATCHDOG_CYCLES = 195000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic tick = 1'b0;
    logic wsel = 1'b0;
    logic run = 1'b1;
    logic gate;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sweep_blank_ctrl dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .blank_req_i  (req),
        .sweep_tick_i (tick),
        .wide_sel_i   (wsel),
        .sweep_run_i  (run),
        .blank_gate_o (gate)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // counts negedges (including the current one) on which gate reads 1
    task automatic count_high(output int n);
        n = 0;
        while (gate && n < WIDE + 10) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_req(input logic w);
        req = 1'b1; wsel = w;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R7 reset gate", gate, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle no request", gate, 0);
    endtask

    task automatic t_length(input logic w, input int exp, input string rq);
        int n;
        tick = 1'b1;
        pulse_req(w);
        check("R1 rises after request", gate, 1);
        count_high(n);
        check(rq, n, exp);
        check("R3 closed after final tick", gate, 0);
    endtask

    task automatic t_restart();
        int n;
        tick = 1'b1;
        pulse_req(1'b0);
        for (int i = 1; i < 5000; i++) @(negedge clk);
        check("R5 open before restart", gate, 1);
        pulse_req(1'b0);
        check("R5 stays open on restart", gate, 1);
        count_high(n);
        check("R5 restart length", n + 5000, 5000 + NARROW);
    endtask

    task automatic t_hold_and_width_change();
        int n;
        tick = 1'b0;
        pulse_req(1'b0);
        for (int i = 0; i < 300; i++) @(negedge clk);
        check("R4 holds without ticks", gate, 1);
        wsel = 1'b1;
        tick = 1'b1;
        count_high(n);
        check("R8 width change ignored", n, NARROW);
        wsel = 1'b0;
    endtask

    task automatic t_stop();
        tick = 1'b1;
        pulse_req(1'b1);
        for (int i = 0; i < 10; i++) @(negedge clk);
        check("R6 open before stop", gate, 1);
        run = 1'b0;
        #1;
        check("R6 shut same cycle", gate, 0);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check("R6 request ignored when stopped", gate, 0);
        run = 1'b1;
        #1;
        check("R6 no reopen on restart of sweep", gate, 0);
        @(negedge clk);
        check("R6 still closed", gate, 0);
    endtask

    task automatic t_reset_mid();
        tick = 1'b1;
        pulse_req(1'b0);
        for (int i = 0; i < 20; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset clears interval", gate, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 stays closed after reset", gate, 0);
    endtask

    initial begin
        t_reset_state();
        t_length(1'b0, NARROW, "R2 R3 narrow length");
        t_length(1'b1, WIDE, "R2 R3 wide length");
        t_restart();
        t_hold_and_width_change();
        t_stop();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule